// File: doc/BRIEF.md
# Capability Descriptor Chain Walker

The walker reads a chain of self-describing, variable-length descriptors out of a read-only capability memory and turns it into a small table that a host can index. Each descriptor starts with one 32-bit header word. The low half of the header is a sub-unit identifier and the high half is a payload length in bytes. The payload follows the header. After a start pulse the walker fetches headers only, beginning at byte offset 0. It jumps over each payload by adding four plus the payload length to the current offset. It stops at the terminator entry, whose identifier is zero.

Each recorded entry holds four things: the identifier, the payload length, the byte offset of its header, and a register-slot base. The slot base comes only from the entry's position in the chain, so entry n owns the 4 KB slot at n × 0x1000. An identifier that appears twice still gets two entries and two slots.

Bad headers stop the walk and set sticky error flags. A header is bad when its identifier is outside 0x0001..0x000F or its length is not word aligned. A chain that would run past the end of the memory, or that fills the table before a terminator appears, also stops the walk with an error.

The memory port is a plain synchronous read with one cycle of latency and no back-pressure. The walker never has more than one read in flight. The host lookup port is combinational.

Top module: `capdesc_walker`

## Requirements
- R1: Each recorded entry keeps header bits 15:0 as its identifier and header bits 31:16 as its payload length in bytes. Both values are returned unchanged by the lookup port.
- R2: A header whose identifier is 0x0000 ends the walk without being counted. `done` then goes to 1, `busy` goes to 0, both error flags stay 0, and `entry_count` holds the number of entries before the terminator.
- R3: The first header is read at byte offset 0. Each following header is read at the previous header offset plus 4 plus that header's length. Payload words are never read, so a clean walk over n entries makes exactly n+1 memory reads.
- R4: The slot base returned for entry index i is i × 0x1000. Entries that share an identifier still get distinct slots.
- R5: `rom_rd_en` is never high on two consecutive cycles. `rom_addr` is the header byte offset divided by 4. Read data is taken in the cycle after the read strobe.
- R6: A header whose identifier is above 0x000F, or whose length is not a multiple of 4, is not counted. It sets `err_format`, ends the walk with `done` = 1, and the flag stays set until the next accepted start.
- R7: After an entry is recorded, if the next header would not fit in the memory (next offset + 4 > 4 × ROM_WORDS), the walk ends with `err_overflow` = 1. The entry that caused the overflow is still counted.
- R8: If a non-terminator header is read while the table already holds ENTRIES entries, that header is not counted. The walk ends with `err_overflow` = 1 and `entry_count` = ENTRIES.
- R9: The lookup port returns the identifier, length, offset and slot base in the same cycle as the index. For any index at or beyond `entry_count` all four outputs are zero.
- R10: A start pulse while `busy` is high has no effect on the walk or its result. A start pulse while idle or done clears the count and both error flags and walks again from offset 0.
- R11: After reset `busy`, `done`, `rom_rd_en`, `entry_count`, `err_format` and `err_overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| rom_rd_en | output | 1 | Memory read strobe |
| rom_addr | output | clog2(ROM_WORDS) | Memory word address |
| rom_rdata | input | 32 | Memory read data, valid the cycle after the strobe |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished (terminator or error) |
| err_format | output | 1 | Sticky: bad identifier or unaligned length |
| err_overflow | output | 1 | Sticky: memory end passed or table full |
| entry_count | output | clog2(ENTRIES+1) | Number of recorded entries |
| lk_idx | input | clog2(ENTRIES+1) | Lookup entry index |
| lk_id | output | 16 | Identifier of the indexed entry |
| lk_len | output | 16 | Payload length of the indexed entry |
| lk_off | output | clog2(ROM_WORDS)+2 | Header byte offset of the indexed entry |
| lk_slot | output | clog2(ENTRIES)+12 | Register-slot base of the indexed entry |

## Verification
The bench builds the walker with ROM_WORDS = 64, a 256-byte memory, and ENTRIES = 4. At these sizes a chain of four short entries fills the table, and a single long payload can land exactly on the last word of the memory or just past it. The bench sweeps every chain length from empty to a full table against several length and identifier patterns. It also makes every lookup index, including the ones past the table, reachable by an exhaustive read-back, so that each halt path and its count and read total can be checked arithmetically.

// File: rtl/capdesc_pkg.sv
package capdesc_pkg;
  typedef enum logic [1:0] {WK_IDLE, WK_ISSUE, WK_WAIT, WK_HALT} walk_st_e;
  localparam int unsigned ID_LAST    = 15;
  localparam int unsigned SLOT_SHIFT = 12;
  localparam int unsigned HDR_BYTES  = 4;
endpackage

// File: rtl/capdesc_hdr_decode.sv
module capdesc_hdr_decode #(
  parameter int unsigned OFFW      = 12,
  parameter int unsigned ROM_BYTES = 4096
) (
  input  logic [31:0]     hdr,
  input  logic [OFFW-1:0] cur_off,
  output logic [15:0]     id,
  output logic [15:0]     len,
  output logic            is_term,
  output logic            is_bad,
  output logic [OFFW-1:0] next_off,
  output logic            past_end
);
  import capdesc_pkg::*;
  localparam int unsigned SUMW = ((OFFW > 16) ? OFFW : 16) + 2;

  logic [SUMW-1:0] sum;

  always_comb begin
    id       = hdr[15:0];
    len      = hdr[31:16];
    is_term  = (id == 16'h0000);
    is_bad   = (id > 16'(ID_LAST)) || (len[1:0] != 2'b00);
    sum      = SUMW'(cur_off) + SUMW'(HDR_BYTES) + SUMW'(len);
    next_off = sum[OFFW-1:0];
    past_end = (sum + SUMW'(HDR_BYTES)) > SUMW'(ROM_BYTES);
  end
endmodule

// File: rtl/capdesc_entry_table.sv
module capdesc_entry_table #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned OFFW    = 12,
  localparam int unsigned CNT_W  = $clog2(ENTRIES + 1),
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                wr,
  input  logic [15:0]         wr_id,
  input  logic [15:0]         wr_len,
  input  logic [OFFW-1:0]     wr_off,
  output logic                full,
  output logic [CNT_W-1:0]    count,
  input  logic [CNT_W-1:0]    lk_idx,
  output logic [15:0]         lk_id,
  output logic [15:0]         lk_len,
  output logic [OFFW-1:0]     lk_off,
  output logic [IDX_W+11:0]   lk_slot
);
  import capdesc_pkg::*;

  logic [15:0]     id_q  [ENTRIES];
  logic [15:0]     len_q [ENTRIES];
  logic [OFFW-1:0] off_q [ENTRIES];
  logic            hit;

  assign full = (count == CNT_W'(ENTRIES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (clr)      count <= '0;
    else if (wr && !full) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr && !full) begin
      id_q[count[IDX_W-1:0]]  <= wr_id;
      len_q[count[IDX_W-1:0]] <= wr_len;
      off_q[count[IDX_W-1:0]] <= wr_off;
    end
  end

  always_comb begin
    hit     = (lk_idx < count);
    lk_id   = '0;
    lk_len  = '0;
    lk_off  = '0;
    lk_slot = '0;
    if (hit) begin
      lk_id   = id_q[lk_idx[IDX_W-1:0]];
      lk_len  = len_q[lk_idx[IDX_W-1:0]];
      lk_off  = off_q[lk_idx[IDX_W-1:0]];
      lk_slot = (IDX_W + 12)'(lk_idx[IDX_W-1:0]) << SLOT_SHIFT;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(ENTRIES)) else $error("count past table size"); // R8
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !full) else $error("write into full table"); // R8
  AST_COUNT_ONLY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> count >= $past(count)) else $error("count dropped without clear"); // R10
endmodule

// File: rtl/capdesc_walk_fsm.sv
module capdesc_walk_fsm #(
  parameter int unsigned OFFW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_term,
  input  logic            is_bad,
  input  logic            past_end,
  input  logic [OFFW-1:0] next_off,
  input  logic            tbl_full,
  output logic            tbl_clr,
  output logic            tbl_wr,
  output logic            rom_rd_en,
  output logic [OFFW-3:0] rom_addr,
  output logic [OFFW-1:0] cur_off,
  output logic            busy,
  output logic            done,
  output logic            err_format,
  output logic            err_overflow
);
  import capdesc_pkg::*;

  walk_st_e st;
  logic     accept;

  assign accept    = start && (st == WK_IDLE || st == WK_HALT);
  assign tbl_clr   = accept;
  assign rom_rd_en = (st == WK_ISSUE);
  assign rom_addr  = cur_off[OFFW-1:2];
  assign busy      = (st == WK_ISSUE) || (st == WK_WAIT);
  assign done      = (st == WK_HALT);
  assign tbl_wr    = (st == WK_WAIT) && !is_term && !is_bad && !tbl_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= WK_IDLE;
      cur_off      <= '0;
      err_format   <= 1'b0;
      err_overflow <= 1'b0;
    end else begin
      unique case (st)
        WK_ISSUE: st <= WK_WAIT;
        WK_WAIT: begin
          if (is_term) begin
            st <= WK_HALT;
          end else if (is_bad) begin
            err_format <= 1'b1;
            st         <= WK_HALT;
          end else if (tbl_full || past_end) begin
            err_overflow <= 1'b1;
            st           <= WK_HALT;
          end else begin
            cur_off <= next_off;
            st      <= WK_ISSUE;
          end
        end
        default: begin
          if (accept) begin
            cur_off      <= '0;
            err_format   <= 1'b0;
            err_overflow <= 1'b0;
            st           <= WK_ISSUE;
          end
        end
      endcase
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_en |=> !rom_rd_en) else $error("back-to-back reads"); // R5
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)) else $error("done while busy"); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_format && !start) |=> err_format) else $error("format error lost"); // R6
  AST_OFFSET_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cur_off >= $past(cur_off)) else $error("offset moved back while busy"); // R10
  AST_HALT_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overflow) |-> done) else $error("overflow without halt"); // R7
endmodule

// File: rtl/capdesc_walker.sv
module capdesc_walker #(
  parameter int unsigned ROM_WORDS = 1024,
  parameter int unsigned ENTRIES   = 32,
  localparam int unsigned OFFW     = $clog2(ROM_WORDS) + 2,
  localparam int unsigned CNT_W    = $clog2(ENTRIES + 1),
  localparam int unsigned IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rom_rd_en,
  output logic [OFFW-3:0]   rom_addr,
  input  logic [31:0]       rom_rdata,
  output logic              busy,
  output logic              done,
  output logic              err_format,
  output logic              err_overflow,
  output logic [CNT_W-1:0]  entry_count,
  input  logic [CNT_W-1:0]  lk_idx,
  output logic [15:0]       lk_id,
  output logic [15:0]       lk_len,
  output logic [OFFW-1:0]   lk_off,
  output logic [IDX_W+11:0] lk_slot
);
  logic [15:0]     d_id, d_len;
  logic            d_term, d_bad, d_past_end;
  logic [OFFW-1:0] d_next, cur_off;
  logic            t_clr, t_wr, t_full;

  capdesc_hdr_decode #(.OFFW(OFFW), .ROM_BYTES(ROM_WORDS * 4)) u_dec (
    .hdr(rom_rdata), .cur_off(cur_off), .id(d_id), .len(d_len),
    .is_term(d_term), .is_bad(d_bad), .next_off(d_next), .past_end(d_past_end)
  );

  capdesc_walk_fsm #(.OFFW(OFFW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .is_term(d_term), .is_bad(d_bad),
    .past_end(d_past_end), .next_off(d_next), .tbl_full(t_full),
    .tbl_clr(t_clr), .tbl_wr(t_wr), .rom_rd_en(rom_rd_en), .rom_addr(rom_addr),
    .cur_off(cur_off), .busy(busy), .done(done),
    .err_format(err_format), .err_overflow(err_overflow)
  );

  capdesc_entry_table #(.ENTRIES(ENTRIES), .OFFW(OFFW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .wr(t_wr), .wr_id(d_id),
    .wr_len(d_len), .wr_off(cur_off), .full(t_full), .count(entry_count),
    .lk_idx(lk_idx), .lk_id(lk_id), .lk_len(lk_len), .lk_off(lk_off),
    .lk_slot(lk_slot)
  );
endmodule

// File: tb/capdesc_walker_test.sv
`timescale 1ns/1ps
module capdesc_walker_test;
  localparam int RW = 64;
  localparam int NE = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic rom_rd_en;
  logic [5:0] rom_addr;
  logic [31:0] rom_rdata;
  logic busy, done, err_format, err_overflow;
  logic [2:0] entry_count, lk_idx;
  logic [15:0] lk_id, lk_len;
  logic [7:0] lk_off;
  logic [13:0] lk_slot;

  always #2.5 clk = ~clk;

  capdesc_walker #(.ROM_WORDS(RW), .ENTRIES(NE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rom_rd_en(rom_rd_en),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .busy(busy), .done(done),
    .err_format(err_format), .err_overflow(err_overflow),
    .entry_count(entry_count), .lk_idx(lk_idx), .lk_id(lk_id),
    .lk_len(lk_len), .lk_off(lk_off), .lk_slot(lk_slot)
  );

  logic [31:0] rom [RW];
  int reads = 0, b2b = 0, addr_bad = 0;
  logic prev_rd = 0;
  int compared = 0, mismatched = 0, cycles = 0;
  int e_id [8];
  int e_len [8];
  int e_off [8];

  always @(posedge clk) begin
    if (rom_rd_en) begin
      rom_rdata <= rom[rom_addr];
      reads <= reads + 1;
      if (prev_rd) b2b <= b2b + 1;
    end
    prev_rd <= rom_rd_en;
  end

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // Build a chain of n headers; optionally append a terminator.
  task automatic build(int n, bit term);
    int o = 0;
    for (int w = 0; w < RW; w++) rom[w] = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      e_off[i] = o;
      if (o / 4 < RW) rom[o / 4] = {e_len[i][15:0], e_id[i][15:0]};
      o = o + 4 + e_len[i];
    end
    if (term && o / 4 < RW) rom[o / 4] = 32'h0;
  endtask

  task automatic walk(bit poke_busy);
    int t = 0;
    @(negedge clk); start = 1; reads = 0; b2b = 0;
    @(negedge clk); start = 0;
    if (poke_busy) begin
      @(negedge clk); @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (!done && t < 2000) begin @(negedge clk); t++; end
    if (!done) chk("R2 walk timeout", 0, 1);
  endtask

  task automatic expect_walk(string tag, int cnt, int fmt, int ovf, int rd);
    chk({tag, " R2 done"}, done, 1);
    chk({tag, " R2 busy"}, busy, 0);
    chk({tag, " count"}, entry_count, cnt);
    chk({tag, " R6 err_format"}, err_format, fmt);
    chk({tag, " R7 err_overflow"}, err_overflow, ovf);
    chk({tag, " R3 reads"}, reads, rd);
    chk({tag, " R5 back-to-back"}, b2b, 0);
    for (int i = 0; i < 8; i++) begin
      lk_idx = 3'(i); #1;
      if (i < cnt) begin
        chk({tag, " R1 id"}, lk_id, e_id[i]);
        chk({tag, " R1 len"}, lk_len, e_len[i]);
        chk({tag, " R3 off"}, lk_off, e_off[i]);
        chk({tag, " R4 slot"}, lk_slot, i * 4096);
      end else begin
        chk({tag, " R9 zero"}, {lk_id, lk_len, 8'(lk_off), 14'(lk_slot)}, 0);
      end
    end
  endtask

  initial begin
    lk_idx = 0;
    repeat (3) @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 rd_en", rom_rd_en, 0);
    chk("R11 count", entry_count, 0);
    chk("R11 errs", {err_format, err_overflow}, 0);
    rst_n = 1;
    @(negedge clk);

    // R4 duplicate identifiers, table exactly full then terminator
    e_id[0] = 1; e_len[0] = 0;  e_id[1] = 2; e_len[1] = 24;
    e_id[2] = 6; e_len[2] = 8;  e_id[3] = 6; e_len[3] = 8;
    build(4, 1); walk(0); expect_walk("dup", 4, 0, 0, 5);

    // Sweep chain lengths and length patterns (R1 R2 R3)
    for (int v = 0; v < 3; v++)
      for (int n = 0; n <= NE; n++) begin
        for (int i = 0; i < n; i++) begin
          e_id[i] = (i * 5 + v) % 15 + 1;
          e_len[i] = 4 * ((i + v) % 4);
        end
        build(n, 1); walk(0); expect_walk("sweep R3", n, 0, 0, n + 1);
      end

    // R6 identifier just past the valid range, after the top valid one
    e_id[0] = 15; e_len[0] = 4; e_id[1] = 16; e_len[1] = 0;
    build(2, 0); walk(0); expect_walk("R6 id", 1, 1, 0, 2);

    // R10 restart clears the error; R6 unaligned length
    e_id[0] = 4; e_len[0] = 0; e_id[1] = 5; e_len[1] = 6;
    build(2, 0); walk(0); expect_walk("R6 len", 1, 1, 0, 2);

    // R8 table full before terminator
    for (int i = 0; i < 5; i++) begin e_id[i] = i + 1; e_len[i] = 0; end
    build(5, 0); walk(0); expect_walk("R8 full", 4, 0, 1, 5);

    // R7 next header would start at the memory end
    e_id[0] = 7; e_len[0] = 252;
    build(1, 0); walk(0); expect_walk("R7 past", 1, 0, 1, 1);

    // R7 boundary: terminator in the last word is still reachable
    e_id[0] = 7; e_len[0] = 248;
    build(1, 1); walk(0); expect_walk("R7 edge", 1, 0, 0, 2);

    // R10 start pulse while busy has no effect
    e_id[0] = 3; e_len[0] = 4; e_id[1] = 9; e_len[1] = 12; e_id[2] = 9; e_len[2] = 0;
    build(3, 1); walk(1); expect_walk("R10 busy start", 3, 0, 0, 4);

    summary();
  end
endmodule